// File: doc/BRIEF.md
# Card Socket Power Sequencer

This block steps a removable card slot through power-up and power-down. It drives two rail selects, one for the card supply and one for the programming supply, and an active-high card reset. A register interface sends it single-cycle enable and disable commands. A free-running timebase supplies a tick pulse, and the block times every phase in those ticks.

An enable command always starts from a cold slot. Both rails go to 0 V and stay there long enough for the supply to collapse. The block then selects 5 V on the card supply and waits for it to settle. It pulses the card reset and waits once more before it reports completion. A disable command drops both rails and waits for the supply to fall. All phases share one down-counter. The counter is loaded with a fixed count on entry to each phase, and its width is derived from the ticks-per-millisecond parameter. A slow simulation timebase therefore shrinks the counter along with the run time.

Rail codes (both selects): 2'b00 selects 0 V, 2'b10 selects 5 V, 2'b01 selects 3.3 V (not used by this sequencer).

Top module: `sock_pwr_seq`

## Requirements
- R1: After reset, vcc_sel_o and vpp_sel_o read 2'b00 (0 V), card_rst_o is low, and busy_o and done_o are both low.
- R2: When idle, an enable command (en_cmd_i high with dis_cmd_i low) raises busy_o and clears done_o on the next clock. Both rails stay at 0 V for 420 ms of ticks (a 20 ms off phase followed by a 400 ms fall phase) before the card supply changes.
- R3: After the off time, vcc_sel_o becomes 2'b10 (5 V) while vpp_sel_o stays 2'b00. This setting holds for 420 ms of ticks before card_rst_o rises.
- R4: card_rst_o stays high for ceil(10 us) of ticks, and for at least one tick. It then falls. After another 20 ms of ticks, busy_o falls and done_o rises, while the card supply stays at 5 V.
- R5: A disable command (dis_cmd_i high) accepted when idle sets both rails to 0 V, holds card_rst_o low and raises busy_o on the next clock. After 320 ms of ticks (20 ms plus 300 ms), busy_o falls and done_o rises.
- R6: An enable command that arrives while a sequence is running is ignored. A disable command that arrives during a power-down is also ignored. In both cases the timing of the running sequence does not change.
- R7: A disable command during any power-up phase aborts it. On the next clock, both rails read 0 V and card_rst_o is low. The full power-down timing then follows.
- R8: When idle, enable and disable in the same cycle run the power-down sequence.
- R9: Phases advance only on tick_i pulses. With tick_i held low, all outputs stay where they are.
- R10: vpp_sel_o always reads 0 V, and vcc_sel_o only ever reads 0 V or 5 V. card_rst_o is high only while vcc_sel_o selects 5 V.
- R11: done_o stays high until the next accepted command, and it is never high together with busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Timebase pulse, TICKS_PER_MS pulses per millisecond |
| en_cmd_i | input | 1 | Power-up command pulse |
| dis_cmd_i | input | 1 | Power-down command pulse |
| vcc_sel_o | output | 2 | Card supply rail select |
| vpp_sel_o | output | 2 | Programming supply rail select |
| card_rst_o | output | 1 | Card reset, active high |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | Last sequence ran to completion |

## Verification
The bench builds the block with TICKS_PER_MS = 2 and drives a tick on every third clock. A full power-up then takes 1721 ticks, about 5200 clocks, so every phase length can be counted exactly at the ports within a short run. At this rate the reset hold rounds up to its one-tick floor, which makes the shortest phase as visible as the longest. Holding the tick low shows that time only advances on ticks. Commands injected part-way through a phase show which commands are ignored and which abort.

// File: rtl/sock_pwr_pkg.sv
package sock_pwr_pkg;

  typedef enum logic [1:0] {
    RAIL_0V  = 2'b00,
    RAIL_3V3 = 2'b01,
    RAIL_5V  = 2'b10
  } rail_e;

  typedef struct packed {
    rail_e vcc;
    rail_e vpp;
  } rails_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP_OFF,
    ST_UP_FALL,
    ST_UP_VCC,
    ST_UP_RST,
    ST_UP_SETTLE,
    ST_DN_OFF,
    ST_DN_FALL
  } seq_state_e;

  // phase lengths
  localparam int unsigned OFF_HOLD_MS   = 20;
  localparam int unsigned UP_FALL_MS    = 400;
  localparam int unsigned VCC_SETTLE_MS = 420;
  localparam int unsigned POST_RST_MS   = 20;
  localparam int unsigned DN_FALL_MS    = 300;
  localparam int unsigned RST_HOLD_US   = 10;
  localparam int unsigned LONGEST_MS    = 420;

endpackage

// File: rtl/sock_tick_timer.sv
module sock_tick_timer #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expire_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (tick_i & (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = tick_i & (cnt_q == CW'(1));

  // R9
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/sock_seq_ctrl.sv
module sock_seq_ctrl
  import sock_pwr_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000,
  parameter int CW           = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_cmd_i,
  input  logic          dis_cmd_i,
  input  logic          expire_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic [1:0]    vcc_sel_o,
  output logic [1:0]    vpp_sel_o,
  output logic          card_rst_o,
  output logic          busy_o,
  output logic          done_o
);

  localparam int RST_RAW = (RST_HOLD_US * TICKS_PER_MS + 999) / 1000;
  localparam int RST_T   = (RST_RAW < 1) ? 1 : RST_RAW;
  localparam logic [CW-1:0] LD_OFF    = CW'(OFF_HOLD_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] LD_UPFALL = CW'(UP_FALL_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] LD_VCC    = CW'(VCC_SETTLE_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] LD_RST    = CW'(RST_T);
  localparam logic [CW-1:0] LD_POST   = CW'(POST_RST_MS * TICKS_PER_MS);
  localparam logic [CW-1:0] LD_DNFALL = CW'(DN_FALL_MS * TICKS_PER_MS);

  seq_state_e state_q, state_d;
  rails_t     rails_q, rails_d;
  logic       rails_en;
  logic       crst_q, crst_d;
  logic       done_q, done_d, done_en;
  logic       in_down;

  assign in_down = (state_q == ST_DN_OFF) || (state_q == ST_DN_FALL);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (dis_cmd_i) state_d = ST_DN_OFF;
                    else if (en_cmd_i) state_d = ST_UP_OFF;
      ST_UP_OFF:    if (dis_cmd_i) state_d = ST_DN_OFF;
                    else if (expire_i) state_d = ST_UP_FALL;
      ST_UP_FALL:   if (dis_cmd_i) state_d = ST_DN_OFF;
                    else if (expire_i) state_d = ST_UP_VCC;
      ST_UP_VCC:    if (dis_cmd_i) state_d = ST_DN_OFF;
                    else if (expire_i) state_d = ST_UP_RST;
      ST_UP_RST:    if (dis_cmd_i) state_d = ST_DN_OFF;
                    else if (expire_i) state_d = ST_UP_SETTLE;
      ST_UP_SETTLE: if (dis_cmd_i) state_d = ST_DN_OFF;
                    else if (expire_i) state_d = ST_IDLE;
      ST_DN_OFF:    if (expire_i) state_d = ST_DN_FALL;
      ST_DN_FALL:   if (expire_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  // phase count load on every entry to a timed phase
  always_comb begin
    load_o = (state_d != state_q) && (state_d != ST_IDLE);
    unique case (state_d)
      ST_UP_OFF, ST_DN_OFF: load_val_o = LD_OFF;
      ST_UP_FALL:           load_val_o = LD_UPFALL;
      ST_UP_VCC:            load_val_o = LD_VCC;
      ST_UP_RST:            load_val_o = LD_RST;
      ST_UP_SETTLE:         load_val_o = LD_POST;
      ST_DN_FALL:           load_val_o = LD_DNFALL;
      default:              load_val_o = '0;
    endcase
  end

  // rails are rewritten as one group; held otherwise (incl. idle)
  always_comb begin
    rails_en = 1'b0;
    rails_d  = rails_q;
    if (load_o && (state_d == ST_UP_OFF || state_d == ST_DN_OFF)) begin
      rails_en = 1'b1;
      rails_d  = '{vcc: RAIL_0V, vpp: RAIL_0V};
    end else if (load_o && state_d == ST_UP_VCC) begin
      rails_en = 1'b1;
      rails_d  = '{vcc: RAIL_5V, vpp: RAIL_0V};
    end
    crst_d  = (state_d == ST_UP_RST);
    done_en = (state_d != state_q) && ((state_d == ST_IDLE) || (state_q == ST_IDLE));
    done_d  = (state_d == ST_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rails_q <= '{vcc: RAIL_0V, vpp: RAIL_0V};
      crst_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      crst_q  <= crst_d;
      if (rails_en) rails_q <= rails_d;
      if (done_en)  done_q  <= done_d;
    end
  end

  assign vcc_sel_o  = rails_q.vcc;
  assign vpp_sel_o  = rails_q.vpp;
  assign card_rst_o = crst_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

  // R10
  rail_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_sel_o == RAIL_0V) && ((vcc_sel_o == RAIL_0V) || (vcc_sel_o == RAIL_5V)));

  // R10
  rst_needs_vcc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rst_o |-> (vcc_sel_o == RAIL_5V));

  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_cmd_i && !dis_cmd_i && !busy_o) |=> (busy_o && !done_o && vcc_sel_o == RAIL_0V));

  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_cmd_i && !in_down) |=> (state_q == ST_DN_OFF && vcc_sel_o == RAIL_0V && !card_rst_o));

  // R6
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_cmd_i && in_down) |=> (state_q != ST_UP_OFF));

  // R11
  done_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

endmodule

// File: rtl/sock_pwr_seq.sv
module sock_pwr_seq
  import sock_pwr_pkg::*;
#(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_cmd_i,
  input  logic       dis_cmd_i,
  output logic [1:0] vcc_sel_o,
  output logic [1:0] vpp_sel_o,
  output logic       card_rst_o,
  output logic       busy_o,
  output logic       done_o
);

  localparam int MAX_TICKS = LONGEST_MS * TICKS_PER_MS;
  localparam int CW        = $clog2(MAX_TICKS + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_n_int;
  logic          load;
  logic [CW-1:0] load_val;
  logic          expire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sock_tick_timer #(.CW(CW)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .expire_o   (expire)
  );

  sock_seq_ctrl #(.TICKS_PER_MS(TICKS_PER_MS), .CW(CW)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .en_cmd_i   (en_cmd_i),
    .dis_cmd_i  (dis_cmd_i),
    .expire_i   (expire),
    .load_o     (load),
    .load_val_o (load_val),
    .vcc_sel_o  (vcc_sel_o),
    .vpp_sel_o  (vpp_sel_o),
    .card_rst_o (card_rst_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

endmodule

// File: tb/sock_pwr_seq_tb_top.sv
module sock_pwr_seq_tb_top;

  localparam int TPM      = 2;
  localparam int TICK_DIV = 3;
  localparam int UP_OFF_T = (20 + 400) * TPM;
  localparam int UP_VCC_T = 420 * TPM;
  localparam int HOLD_T   = 1;
  localparam int UP_END_T = 20 * TPM;
  localparam int DN_T     = (20 + 300) * TPM;
  localparam logic [1:0] V0 = 2'b00;
  localparam logic [1:0] V5 = 2'b10;

  logic clk = 1'b0;
  logic rst_n;
  logic tick = 1'b0;
  logic en_cmd, dis_cmd;
  logic [1:0] vcc, vpp;
  logic crst, busy, done;

  int  n_chk = 0;
  int  n_bad = 0;
  int  tick_cnt = 0;
  int  t_next = 0;
  bit  tick_run = 1'b1;
  int  div = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  sock_pwr_seq #(.TICKS_PER_MS(TPM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .en_cmd_i(en_cmd), .dis_cmd_i(dis_cmd),
    .vcc_sel_o(vcc), .vpp_sel_o(vpp), .card_rst_o(crst),
    .busy_o(busy), .done_o(done)
  );

  // tick changes just after a rising edge, stable at the falling edge
  always @(posedge clk) begin
    #1;
    div  = (div + 1) % TICK_DIV;
    tick = tick_run && (div == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk);
    tick_cnt += t_next;
    t_next = int'(tick);
  endtask

  task automatic pulse(input logic e, input logic d);
    en_cmd = e; dis_cmd = d;
    step();
    en_cmd = 1'b0; dis_cmd = 1'b0;
  endtask

  function automatic logic [6:0] outs();
    return {vcc, vpp, crst, busy, done};
  endfunction

  task automatic wait_change(output int ticks);
    logic [6:0] snap = outs();
    int start = tick_cnt;
    for (int c = 0; c < 6000; c++) begin
      step();
      if (outs() != snap) break;
    end
    ticks = tick_cnt - start;
    chk(vpp == V0, "R10 vpp", int'(vpp), int'(V0));
  endtask

  task automatic t_reset();
    chk(vcc == V0 && vpp == V0, "R1 rails", int'({vcc, vpp}), 0);
    chk(!crst && !busy && !done, "R1 flags", int'({crst, busy, done}), 0);
  endtask

  task automatic t_enable_full();
    int n;
    pulse(1'b1, 1'b0);
    chk(busy && !done && vcc == V0, "R2 start", int'({busy, done, vcc}), 4'b1000);
    wait_change(n);
    chk(n == UP_OFF_T, "R2 off time", n, UP_OFF_T);
    chk(vcc == V5 && vpp == V0 && !crst, "R3 vcc on", int'({vcc, vpp, crst}), 5'b10000);
    wait_change(n);
    chk(n == UP_VCC_T, "R3 settle time", n, UP_VCC_T);
    chk(crst == 1'b1, "R3 reset rises", int'(crst), 1);
    wait_change(n);
    chk(n == HOLD_T, "R4 reset hold", n, HOLD_T);
    chk(!crst && busy && vcc == V5, "R4 reset falls", int'({crst, busy}), 1);
    wait_change(n);
    chk(n == UP_END_T, "R4 post wait", n, UP_END_T);
    chk(!busy && done && vcc == V5, "R4 done", int'({busy, done, vcc}), 3'b110);
    repeat (30) step();
    chk(done && vcc == V5, "R11 done held", int'(done), 1);
  endtask

  task automatic t_disable();
    int n;
    pulse(1'b0, 1'b1);
    chk(busy && !done && vcc == V0 && !crst, "R5 start", int'({busy, done, vcc}), 4'b1000);
    wait_change(n);
    chk(n == DN_T, "R5 down time", n, DN_T);
    chk(!busy && done && vcc == V0, "R5 done", int'({busy, done}), 1);
  endtask

  task automatic t_ignore_en();
    int n, start;
    pulse(1'b1, 1'b0);
    start = tick_cnt;
    repeat (10) step();
    pulse(1'b1, 1'b0);
    chk(busy && vcc == V0, "R6 enable ignored", int'(busy), 1);
    wait_change(n);
    chk(tick_cnt - start == UP_OFF_T, "R6 timing kept", tick_cnt - start, UP_OFF_T);
    repeat (20) step();
    pulse(1'b0, 1'b1);
    start = tick_cnt;
    repeat (7) step();
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    chk(busy && vcc == V0, "R6 down unaffected", int'(busy), 1);
    wait_change(n);
    chk(tick_cnt - start == DN_T, "R6 down timing kept", tick_cnt - start, DN_T);
    chk(done && !busy && vcc == V0, "R6 down done", int'(done), 1);
  endtask

  task automatic t_abort();
    int n;
    pulse(1'b1, 1'b0);
    wait_change(n);
    repeat (12) step();
    chk(vcc == V5, "R7 precondition", int'(vcc), int'(V5));
    pulse(1'b0, 1'b1);
    chk(vcc == V0 && !crst && busy, "R7 abort", int'({vcc, crst, busy}), 1);
    wait_change(n);
    chk(n == DN_T, "R7 down time", n, DN_T);
    chk(done && !busy, "R7 done", int'(done), 1);
  endtask

  task automatic t_both();
    int n;
    pulse(1'b1, 1'b1);
    chk(busy && vcc == V0, "R8 start", int'(busy), 1);
    wait_change(n);
    chk(n == DN_T, "R8 disable wins", n, DN_T);
  endtask

  task automatic t_no_tick();
    int n, start;
    tick_run = 1'b0;
    step(); step();
    pulse(1'b1, 1'b0);
    start = tick_cnt;
    repeat (3000) step();
    chk(busy && vcc == V0 && !crst, "R9 stalled", int'({busy, vcc}), 4);
    chk(tick_cnt == start, "R9 no ticks", tick_cnt - start, 0);
    tick_run = 1'b1;
    wait_change(n);
    chk(tick_cnt - start == UP_OFF_T, "R9 resumes", tick_cnt - start, UP_OFF_T);
    pulse(1'b0, 1'b1);
    wait_change(n);
  endtask

  initial begin
    rst_n = 1'b0; en_cmd = 1'b0; dis_cmd = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_next = int'(tick);
    t_reset();
    t_enable_full();
    t_disable();
    t_ignore_en();
    t_abort();
    t_both();
    t_enable_full();
    t_no_tick();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
  end

endmodule